// File: doc/BRIEF.md
# Programmable Down-Counter Channel with Capture Readback

This block is a single 16-bit down-counting timer channel driven through an 8-bit host port. The host writes a control byte that gives the channel its byte access pattern, its counting mode and its number base (binary or four-digit BCD), then loads a start value N through the data address. A count-enable strobe `tick`, sampled on the system clock, advances the counting element, a `gate` input suspends it, and `cnt_out` is the channel's waveform output.

Reading the data address returns the live count unless a capture is pending. A capture freezes the count in a hold register and/or the status byte in a status register, either through a per-channel latch command or through a multi-channel capture command. Captures are one-shot: once taken they ignore new capture requests until read out, and a pending status byte always comes out before a pending count.

Top module: `ictr_chan`

## Requirements
- R1: A control byte (addr=1) whose bits 7:6 equal `CHAN_ID` and whose bits 5:4 are not 00 sets access mode (bits 5:4), counting mode (bits 3:1) and BCD flag (bit 0), and restarts both byte pointers and clears any capture; bytes for another channel number leave the channel untouched. After reset the access mode is 11, the mode is 0, counting is binary, the output is low and the count reads 0.
- R2: Access mode 01 moves the low byte only (a write clears the high byte), mode 10 the high byte only (a write clears the low byte), and mode 11 moves the low byte then the high byte, with separate alternating pointers for writes and reads.
- R3: A control byte for this channel with bits 5:4 = 00 copies the count into a hold register; data reads then return the held value while counting continues, and with no capture pending reads return the live count.
- R4: While a count capture is unread, further count-capture requests have no effect; the hold register frees after its last byte (per access mode) is read.
- R5: A control byte with bits 7:6 = 11 is a capture command: bit 5 low captures the count, bit 4 low captures the status, and the channel takes part only if bit (1+`CHAN_ID`) is set.
- R6: The status byte is {output, null-count, access mode[1:0], mode[2:0], BCD} from bit 7 down; null-count is set by a control write or a completed count write and cleared when that count reaches the counting element.
- R7: With both captures pending in access mode 11, reads return status, then low byte, then high byte; a status capture taken after an unread count capture is still read first.
- R8: In mode 0 (and codes 1, 4, 5), the output goes low on the control write and on a completed count write, and goes high on the tick that brings the count to zero; it stays high while the count wraps, until the next count write.
- R9: In mode 2 (codes 2, 6) with N >= 2, the output is high, goes low for exactly one tick when the count reaches 1, then the count reloads N, giving a period of N ticks.
- R10: In mode 3 (codes 3, 7) with N >= 2, the output is high for (N+1)/2 ticks and low for N/2 ticks (integer division), repeating with period N.
- R11: With `gate` low the counting element does not change (except for a pending load); in modes 2 and 3 the output is forced high.
- R12: With the BCD flag set the count decrements in decimal digits and 0000 wraps to 9999; in binary 0000 wraps to FFFF.
- R13: A completed count write is transferred into the counting element on the next tick, with no decrement on that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (advances read state) |
| addr | input | 1 | 0 = data, 1 = control |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte for the current read state |
| tick | input | 1 | Count-enable strobe |
| gate | input | 1 | Counting permit, high to count |
| cnt_out | output | 1 | Channel output waveform |

## Verification
On every cycle the assertions check that a fresh count capture equals the count of the cycle it was requested in, that repeated capture requests leave the hold register alone, that a count write raises null-count, that a mode-0 count write drops the output, that a mode-2 low output lasts one tick, and that a low gate freezes the count. The output waveforms over whole periods for odd and even N, the status-then-count read order, decimal decrement and wrap, the byte access patterns and the rejection of control bytes for other channels can only be shown by the bench's scenarios, which compare port reads against values computed from the requirements.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int DIG_W  = 4;

  typedef enum logic [1:0] {
    ACC_CAPT = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] op;
    logic       bcd;
  } cfg_t;

  function automatic logic op_periodic(input logic [2:0] op);
    return op[1];
  endfunction

  function automatic logic op_square(input logic [2:0] op);
    return op[1] & op[0];
  endfunction
endpackage

// File: rtl/ictr_decode.sv
module ictr_decode
  import ictr_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wdata,
  output cfg_t              cfg_q,
  output logic [CNT_W-1:0]  cr_q,
  output logic              ctrl_evt,
  output logic [2:0]        ctrl_op,
  output logic              count_evt,
  output logic              lat_cnt_req,
  output logic              lat_sta_req
);
  localparam logic [1:0] CHAN_CODE = CHAN_ID[1:0];
  localparam int         RB_SEL    = 1 + CHAN_ID;

  logic              wr_ptr_q, wr_ptr_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [CNT_W-1:0]  cr_d;
  cfg_t              cfg_d;
  logic              ctrl_wr, data_wr, sel_me, is_rb, rb_me;

  always_comb begin
    ctrl_wr     = wr_en & addr;
    data_wr     = wr_en & ~addr;
    sel_me      = (wdata[7:6] == CHAN_CODE);
    is_rb       = (wdata[7:6] == 2'b11);
    rb_me       = is_rb & wdata[RB_SEL];
    ctrl_evt    = ctrl_wr & sel_me & (wdata[5:4] != 2'b00);
    ctrl_op     = wdata[3:1];
    lat_cnt_req = ctrl_wr & ((sel_me & (wdata[5:4] == 2'b00)) | (rb_me & ~wdata[5]));
    lat_sta_req = ctrl_wr & rb_me & ~wdata[4];
    count_evt   = data_wr & ((cfg_q.acc != ACC_LOHI) | wr_ptr_q);
  end

  always_comb begin
    cfg_d    = cfg_q;
    cr_d     = cr_q;
    lo_d     = lo_q;
    wr_ptr_d = wr_ptr_q;
    if (ctrl_evt) begin
      cfg_d    = cfg_t'(wdata[5:0]);
      wr_ptr_d = 1'b0;
    end else if (data_wr) begin
      unique case (cfg_q.acc)
        ACC_LO:   cr_d = {{BYTE_W{1'b0}}, wdata};
        ACC_HI:   cr_d = {wdata, {BYTE_W{1'b0}}};
        ACC_LOHI: begin
          if (!wr_ptr_q) begin
            lo_d     = wdata;
            wr_ptr_d = 1'b1;
          end else begin
            cr_d     = {wdata, lo_q};
            wr_ptr_d = 1'b0;
          end
        end
        default: cr_d = cr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{acc: ACC_LOHI, op: 3'd0, bcd: 1'b0};
      cr_q     <= '0;
      lo_q     <= '0;
      wr_ptr_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      cr_q     <= cr_d;
      lo_q     <= lo_d;
      wr_ptr_q <= wr_ptr_d;
    end
  end
endmodule

// File: rtl/ictr_engine.sv
module ictr_engine
  import ictr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate,
  input  logic [2:0]       op,
  input  logic             bcd,
  input  logic [CNT_W-1:0] cr,
  input  logic             ctrl_evt,
  input  logic [2:0]       ctrl_op,
  input  logic             count_evt,
  output logic [CNT_W-1:0] ce_q,
  output logic             out_q,
  output logic             null_q,
  output logic             pend_q
);
  localparam int               NDIG = CNT_W / DIG_W;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

  logic [CNT_W-1:0] ce_d;
  logic             out_d, null_d, pend_d, run_q, run_d, extra_q, extra_d;
  logic             periodic, square;
  logic [CNT_W-1:0] cr_even, dec_one, dec_two;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v, input logic dec);
    logic [CNT_W-1:0] r;
    logic             borrow;
    if (!dec) return v - ONE;
    r      = v;
    borrow = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (borrow) begin
        if (v[i*DIG_W +: DIG_W] == 4'd0) begin
          r[i*DIG_W +: DIG_W] = 4'd9;
        end else begin
          r[i*DIG_W +: DIG_W] = v[i*DIG_W +: DIG_W] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  always_comb begin
    periodic = op_periodic(op);
    square   = op_square(op);
    cr_even  = {cr[CNT_W-1:1], 1'b0};
    dec_one  = step_down(ce_q, bcd);
    dec_two  = step_down(dec_one, bcd);
  end

  always_comb begin
    ce_d    = ce_q;
    out_d   = out_q;
    null_d  = null_q;
    pend_d  = pend_q;
    run_d   = run_q;
    extra_d = extra_q;
    if (ctrl_evt) begin
      out_d   = op_periodic(ctrl_op);
      null_d  = 1'b1;
      pend_d  = 1'b0;
      run_d   = 1'b0;
      extra_d = 1'b0;
    end else begin
      if (count_evt) begin
        pend_d = 1'b1;
        null_d = 1'b1;
        if (!periodic) out_d = 1'b0;
      end
      if (tick) begin
        if (pend_q) begin
          ce_d    = square ? cr_even : cr;
          run_d   = 1'b1;
          pend_d  = count_evt;
          null_d  = count_evt;
          extra_d = square & cr[0];
          if (periodic) out_d = 1'b1;
        end else if (run_q && gate) begin
          if (!periodic) begin
            ce_d = dec_one;
            if (ce_q == ONE && !count_evt) out_d = 1'b1;
          end else if (!square) begin
            if (ce_q == ONE) begin
              ce_d  = cr;
              out_d = 1'b1;
            end else begin
              ce_d = dec_one;
              if (ce_q == TWO) out_d = 1'b0;
            end
          end else begin
            if (ce_q == TWO) begin
              if (extra_q) begin
                extra_d = 1'b0;
              end else begin
                out_d   = ~out_q;
                ce_d    = cr_even;
                extra_d = cr[0] & ~out_q;
              end
            end else begin
              ce_d = dec_two;
            end
          end
        end
      end
      if (periodic && !gate) out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= '0;
      out_q   <= 1'b0;
      null_q  <= 1'b0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      ce_q    <= ce_d;
      out_q   <= out_d;
      null_q  <= null_d;
      pend_q  <= pend_d;
      run_q   <= run_d;
      extra_q <= extra_d;
    end
  end
endmodule

// File: rtl/ictr_readout.sv
module ictr_readout
  import ictr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              addr,
  input  acc_e              acc,
  input  logic [CNT_W-1:0]  ce,
  input  logic [BYTE_W-1:0] sta_now,
  input  logic              ctrl_evt,
  input  logic              lat_cnt_req,
  input  logic              lat_sta_req,
  output logic [BYTE_W-1:0] rdata,
  output logic              cnt_lat_q,
  output logic [CNT_W-1:0]  hold_q
);
  logic              cnt_lat_d, sta_lat_q, sta_lat_d, rd_ptr_q, rd_ptr_d, rd_evt, hi_sel;
  logic [CNT_W-1:0]  hold_d, src;
  logic [BYTE_W-1:0] sta_q, sta_d;

  always_comb begin
    rd_evt = rd_en & ~addr;
    src    = cnt_lat_q ? hold_q : ce;
    hi_sel = (acc == ACC_HI) | ((acc == ACC_LOHI) & rd_ptr_q);
    if (sta_lat_q)   rdata = sta_q;
    else if (hi_sel) rdata = src[CNT_W-1:BYTE_W];
    else             rdata = src[BYTE_W-1:0];
  end

  always_comb begin
    cnt_lat_d = cnt_lat_q;
    sta_lat_d = sta_lat_q;
    rd_ptr_d  = rd_ptr_q;
    hold_d    = hold_q;
    sta_d     = sta_q;
    if (ctrl_evt) begin
      cnt_lat_d = 1'b0;
      sta_lat_d = 1'b0;
      rd_ptr_d  = 1'b0;
    end else begin
      if (rd_evt) begin
        if (sta_lat_q) begin
          sta_lat_d = 1'b0;
        end else begin
          if (acc == ACC_LOHI) rd_ptr_d = ~rd_ptr_q;
          if (cnt_lat_q && ((acc != ACC_LOHI) || rd_ptr_q)) cnt_lat_d = 1'b0;
        end
      end
      if (lat_cnt_req && !cnt_lat_q) begin
        hold_d    = ce;
        cnt_lat_d = 1'b1;
      end
      if (lat_sta_req && !sta_lat_q) begin
        sta_d     = sta_now;
        sta_lat_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lat_q <= 1'b0;
      sta_lat_q <= 1'b0;
      rd_ptr_q  <= 1'b0;
      hold_q    <= '0;
      sta_q     <= '0;
    end else begin
      cnt_lat_q <= cnt_lat_d;
      sta_lat_q <= sta_lat_d;
      rd_ptr_q  <= rd_ptr_d;
      hold_q    <= hold_d;
      sta_q     <= sta_d;
    end
  end
endmodule

// File: rtl/ictr_chan.sv
module ictr_chan
  import ictr_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              tick,
  input  logic              gate,
  output logic              cnt_out
);
  logic             rst_meta_q, rst_n_s;
  cfg_t             cfg_q;
  logic [CNT_W-1:0] cr_q, ce_q, hold_q;
  logic             ctrl_evt, count_evt, lat_cnt_req, lat_sta_req;
  logic [2:0]       ctrl_op;
  logic             out_q, null_q, pend_q, cnt_lat_q;
  logic [BYTE_W-1:0] sta_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  ictr_decode #(.CHAN_ID(CHAN_ID)) u_dec (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cfg_q(cfg_q), .cr_q(cr_q), .ctrl_evt(ctrl_evt), .ctrl_op(ctrl_op),
    .count_evt(count_evt), .lat_cnt_req(lat_cnt_req), .lat_sta_req(lat_sta_req)
  );

  ictr_engine u_eng (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .gate(gate),
    .op(cfg_q.op), .bcd(cfg_q.bcd), .cr(cr_q),
    .ctrl_evt(ctrl_evt), .ctrl_op(ctrl_op), .count_evt(count_evt),
    .ce_q(ce_q), .out_q(out_q), .null_q(null_q), .pend_q(pend_q)
  );

  always_comb sta_now = {out_q, null_q, cfg_q.acc, cfg_q.op, cfg_q.bcd};

  ictr_readout u_rd (
    .clk(clk), .rst_n(rst_n_s), .rd_en(rd_en), .addr(addr), .acc(cfg_q.acc),
    .ce(ce_q), .sta_now(sta_now), .ctrl_evt(ctrl_evt),
    .lat_cnt_req(lat_cnt_req), .lat_sta_req(lat_sta_req),
    .rdata(rdata), .cnt_lat_q(cnt_lat_q), .hold_q(hold_q)
  );

  assign cnt_out = out_q;
endmodule

// File: rtl/ictr_chan_chk.sv
module ictr_chan_chk
  import ictr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             gate,
  input logic             cnt_out,
  input logic [2:0]       op,
  input logic [CNT_W-1:0] ce,
  input logic [CNT_W-1:0] hold,
  input logic             cnt_lat,
  input logic             lat_cnt_req,
  input logic             count_evt,
  input logic             ctrl_evt,
  input logic             null_flag,
  input logic             pend
);
  // R3
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_lat) |-> hold == $past(ce));

  // R4
  capture_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_lat && lat_cnt_req) |=> $stable(hold));

  // R6
  null_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_evt |=> null_flag);

  // R8
  tc_load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_evt && !op[1]) |=> !cnt_out);

  // R9
  rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op[1:0] == 2'b10 && !cnt_out && tick && !ctrl_evt) |=> cnt_out);

  // R11
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !(tick && pend)) |=> $stable(ce));
endmodule

bind ictr_chan ictr_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .tick(tick), .gate(gate), .cnt_out(cnt_out),
  .op(cfg_q.op), .ce(ce_q), .hold(hold_q), .cnt_lat(cnt_lat_q),
  .lat_cnt_req(lat_cnt_req), .count_evt(count_evt), .ctrl_evt(ctrl_evt),
  .null_flag(null_q), .pend(pend_q)
);

// File: tb/ictr_chan_test.sv
module ictr_chan_test;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, wr_en, rd_en, addr, tick, gate;
  logic [7:0] wdata, rdata;
  logic       cnt_out;
  int         checks, fails;
  bit         done;

  ictr_chan #(.CHAN_ID(0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate), .cnt_out(cnt_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r;
    int          t;
    t = v;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic exp_rate(input int s, input int n);
    return !((s >= 2) && (((s - 1) % n) == n - 1));
  endfunction

  function automatic logic exp_square(input int s, input int n);
    return (((s - 1) % n) < ((n + 1) / 2));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    rd_en = 1'b1; addr = 1'b0;
    d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(lo);
    rd(hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wave_test(input logic [7:0] ctrl, input int n, input bit sq, input string req);
    int bad;
    bad = 0;
    tick = 1'b0;
    wr(1'b1, ctrl);
    wr(1'b0, n[7:0]);
    tick = 1'b1;
    wr(1'b0, n[15:8]);
    for (int s = 1; s <= 3 * n + 1; s++) begin
      @(negedge clk);
      if (cnt_out !== (sq ? exp_square(s, n) : exp_rate(s, n))) bad++;
    end
    tick = 1'b0;
    chk(req, bad, 0);
  endtask

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    int          n, k, dv;
    checks = 0; fails = 0; done = 1'b0;
    wr_en = 0; rd_en = 0; addr = 0; wdata = 0; tick = 0; gate = 1;
    rst_n = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset out", cnt_out, 0);
    chk("R1 reset count", rdata, 8'h00);
    wr(1'b1, 8'hE2); rd(b);
    chk("R1 reset status", b, 8'h30);

    // R8 R6 R13 mode 0
    wr(1'b1, 8'h30);
    chk("R8 out low on control", cnt_out, 0);
    wr(1'b0, 8'd5); wr(1'b0, 8'd0);
    wr(1'b1, 8'hE2); rd(b);
    chk("R6 null set", b, 8'h70);
    ticks(1);
    wr(1'b1, 8'hE2); rd(b);
    chk("R6 null cleared", b, 8'h30);
    rd16(v);
    chk("R13 no decrement on load", v, 16'd5);
    ticks(4);
    chk("R8 still low", cnt_out, 0);
    rd16(v);
    chk("R3 live read", v, 16'd1);
    ticks(1);
    chk("R8 high at zero", cnt_out, 1);
    ticks(3);
    chk("R8 stays high", cnt_out, 1);
    rd16(v);
    chk("R12 binary wrap", v, 16'hFFFD);

    // R3 R4 R7 R5 capture behaviour
    wr(1'b1, 8'h30); wr(1'b0, 8'hE8); wr(1'b0, 8'h03);
    ticks(1); ticks(7);
    wr(1'b1, 8'h00);
    ticks(10);
    rd16(v); chk("R3 held value", v, 16'd993);
    rd16(v); chk("R3 live after hold", v, 16'd983);
    wr(1'b1, 8'h00); ticks(2);
    wr(1'b1, 8'h00); ticks(2);
    rd16(v); chk("R4 second capture ignored", v, 16'd983);
    rd16(v); chk("R4 live", v, 16'd979);
    wr(1'b1, 8'h00);
    rd16(v); chk("R4 capture after release", v, 16'd979);
    ticks(1);
    wr(1'b1, 8'hC2); ticks(2);
    rd(b); chk("R7 status first", b, 8'h30);
    rd16(v); chk("R7 count after status", v, 16'd978);
    wr(1'b1, 8'h00); ticks(1);
    wr(1'b1, 8'hE2);
    rd(b); chk("R7 late status first", b, 8'h30);
    rd16(v); chk("R7 earlier count kept", v, 16'd976);
    wr(1'b1, 8'hD4); ticks(3);
    rd16(v); chk("R5 unselected capture ignored", v, 16'd972);
    wr(1'b1, 8'h54);
    wr(1'b1, 8'hE2); rd(b);
    chk("R1 other channel ignored", b, 8'h30);

    // R2 byte access patterns
    wr(1'b1, 8'h10); wr(1'b0, 8'h34); ticks(1);
    rd(b); chk("R2 low only", b, 8'h34);
    rd(b); chk("R2 low only repeat", b, 8'h34);
    wr(1'b1, 8'hE2); rd(b);
    chk("R6 status access 01", b, 8'h10);
    wr(1'b1, 8'h20); wr(1'b0, 8'h12); ticks(1);
    rd(b); chk("R2 high only", b, 8'h12);
    ticks(1);
    rd(b); chk("R2 high only after borrow", b, 8'h11);

    // R9 R10 waveforms
    wave_test(8'h34, 2, 1'b0, "R9 rate N=2");
    for (int i = 0; i < 3; i++) begin
      n = 2 + int'($urandom % 16);
      wave_test(8'h34, n, 1'b0, "R9 rate random");
    end
    wave_test(8'h36, 5, 1'b1, "R10 square odd");
    wave_test(8'h36, 6, 1'b1, "R10 square even");
    wave_test(8'h36, 3, 1'b1, "R10 square N=3");
    for (int i = 0; i < 3; i++) begin
      n = 2 + int'($urandom % 17);
      wave_test(8'h36, n, 1'b1, "R10 square random");
    end

    // R11 gate
    wr(1'b1, 8'h34); wr(1'b0, 8'd50); wr(1'b0, 8'd0);
    ticks(1); tick = 1'b1;
    repeat (5) @(negedge clk);
    gate = 1'b0;
    @(negedge clk);
    chk("R11 out forced high", cnt_out, 1);
    rd16(v);
    repeat (5) @(negedge clk);
    begin
      logic [15:0] v2;
      rd16(v2);
      chk("R11 count frozen", v2, v);
    end
    gate = 1'b1; tick = 1'b0;

    // R12 BCD
    wr(1'b1, 8'h31); wr(1'b0, 8'h00); wr(1'b0, 8'h10);
    ticks(2);
    rd16(v); chk("R12 bcd borrow", v, 16'h0999);
    for (int i = 0; i < 3; i++) begin
      dv = 1 + int'($urandom % 9999);
      k  = int'($urandom % 200) % dv;
      wr(1'b1, 8'h31);
      v = to_bcd(dv);
      wr(1'b0, v[7:0]); wr(1'b0, v[15:8]);
      ticks(1 + k);
      rd16(v); chk("R12 bcd random", v, to_bcd(dv - k));
    end
    wr(1'b1, 8'h31); wr(1'b0, 8'h00); wr(1'b0, 8'h00);
    ticks(2);
    rd16(v); chk("R12 bcd wrap", v, 16'h9999);
    ticks(1);
    rd16(v); chk("R12 bcd after wrap", v, 16'h9998);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule